// File: doc/BRIEF.md
# Decode-Stage Branch Resolution Unit

This block settles conditional branches and jumps while the instruction is still in the decode stage of a five-stage in-order pipeline. The fetch stage always runs ahead on the sequential path (a not-taken guess). When the instruction in decode resolves taken, the block asserts a redirect and supplies the new fetch address. In the same cycle it raises a flush, so the one sequential instruction that was fetched under the wrong guess is squashed. The cost of a taken branch is therefore one lost slot, and a branch that falls through costs nothing.

The unit contains three parts. The comparator tests the two source operands under the selected condition. The target adder forms either PC plus immediate or register plus immediate. The third part is the fetch/decode pipeline register, which the squash control overwrites with a no-operation word. The link value (PC + 4) is supplied for jumps that write a return address. Operands reach the block already resolved; forwarding into decode lies outside this block.

Top module: `branch_resolve_unit`

## Requirements
- R1: While rst_n is low and on the first edge after it, the fetch/decode register holds the no-operation word 0x00000013 with a PC of zero, and redirect and flush are low whenever dec_valid is low.
- R2: The br_kind codes select the conditional branches: 1 equal, 2 not equal, 3 signed less than, 4 signed greater or equal, 5 unsigned less than, 6 unsigned greater or equal. With dec_valid high and dec_stall low, redirect is high in the same cycle exactly when the condition on src_a versus src_b holds.
- R3: For a taken conditional branch (codes 1 to 6), target equals dec_pc plus dec_imm, taken modulo 2^XLEN.
- R4: Code 7 (jump-and-link) always redirects when resolved, with target dec_pc plus dec_imm and link equal to dec_pc plus 4.
- R5: Code 8 (register-indirect jump) always redirects when resolved, with target (src_a plus dec_imm) and bit 0 forced to zero, and link equal to dec_pc plus 4.
- R6: flush is high in exactly the cycles in which redirect is high, and on the following clock edge the fetch/decode register loads the no-operation word with a PC of zero instead of the fetched instruction.
- R7: When nothing is taken and dec_stall is low, flush stays low and the fetch/decode register loads fetch_instr and fetch_pc on the next edge, so no cycle is lost.
- R8: While dec_stall is high, redirect and flush stay low whatever the branch outcome, and the fetch/decode register keeps its contents across the edge.
- R9: With dec_valid low, or with br_kind 0 or any code from 9 to 15, redirect and flush stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| dec_valid | input | 1 | Decode stage holds a real instruction |
| dec_stall | input | 1 | Decode held by an interlock this cycle |
| br_kind | input | 4 | Branch or jump kind code (see R2, R4, R5, R9) |
| src_a | input | XLEN | First source operand |
| src_b | input | XLEN | Second source operand |
| dec_pc | input | XLEN | PC of the instruction in decode |
| dec_imm | input | XLEN | Sign-extended immediate |
| fetch_instr | input | ILEN | Instruction word from fetch |
| fetch_pc | input | XLEN | PC of the fetched word |
| redirect | output | 1 | Next-PC select: take target instead of PC + 4 |
| target | output | XLEN | Redirect address |
| link | output | XLEN | Return address, decode PC + 4 |
| flush | output | 1 | Squash of the fetch/decode register |
| ifid_instr | output | ILEN | Fetch/decode register instruction |
| ifid_pc | output | XLEN | Fetch/decode register PC |

## Verification
redirect, flush, target and link are combinational, so they are due in the same cycle as the decode inputs. The bench drives inputs on the falling edge and samples these outputs one nanosecond later. The fetch/decode register result is due at the next rising edge. Its expected value is computed before that edge, and the register is sampled one nanosecond after the edge, well before the next falling-edge drive. Random kinds, operands and stalls run alongside directed cases: equal operands, a sign-bit split that separates the signed and unsigned orderings, an odd indirect target, a stall over a taken branch, and unused kind codes.

// File: rtl/brres_pkg.sv
package brres_pkg;

  typedef enum logic [3:0] {
    BK_NONE = 4'd0,
    BK_EQ   = 4'd1,
    BK_NE   = 4'd2,
    BK_LT   = 4'd3,
    BK_GE   = 4'd4,
    BK_LTU  = 4'd5,
    BK_GEU  = 4'd6,
    BK_JAL  = 4'd7,
    BK_JALR = 4'd8
  } br_kind_e;

  // Decide taken from comparison flags; jumps are unconditional.
  function automatic logic cond_from_flags(input logic [3:0] kind,
                                           input logic eq,
                                           input logic lt_s,
                                           input logic lt_u);
    logic r;
    case (kind)
      BK_EQ:   r = eq;
      BK_NE:   r = !eq;
      BK_LT:   r = lt_s;
      BK_GE:   r = !lt_s;
      BK_LTU:  r = lt_u;
      BK_GEU:  r = !lt_u;
      BK_JAL:  r = 1'b1;
      BK_JALR: r = 1'b1;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

  function automatic logic is_indirect(input logic [3:0] kind);
    return kind == BK_JALR;
  endfunction

endpackage

// File: rtl/br_compare.sv
module br_compare #(
  parameter int XLEN = 32
) (
  input  logic [3:0]      kind,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            cond_true,
  output logic            eq_flag,
  output logic            lts_flag,
  output logic            ltu_flag
);
  import brres_pkg::*;

  function automatic logic signed_less(input logic [XLEN-1:0] x,
                                       input logic [XLEN-1:0] y);
    return $signed(x) < $signed(y);
  endfunction

  function automatic logic unsigned_less(input logic [XLEN-1:0] x,
                                         input logic [XLEN-1:0] y);
    return x < y;
  endfunction

  always_comb begin
    eq_flag   = (a == b);
    lts_flag  = signed_less(a, b);
    ltu_flag  = unsigned_less(a, b);
    cond_true = cond_from_flags(kind, eq_flag, lts_flag, ltu_flag);
  end

endmodule

// File: rtl/br_target.sv
module br_target #(
  parameter int XLEN = 32
) (
  input  logic [3:0]      kind,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] base_reg,
  input  logic [XLEN-1:0] imm,
  output logic [XLEN-1:0] target,
  output logic [XLEN-1:0] link
);
  import brres_pkg::*;

  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  function automatic logic [XLEN-1:0] pc_rel(input logic [XLEN-1:0] p,
                                             input logic [XLEN-1:0] i);
    return p + i;
  endfunction

  function automatic logic [XLEN-1:0] reg_rel(input logic [XLEN-1:0] r,
                                              input logic [XLEN-1:0] i);
    logic [XLEN-1:0] s;
    s = r + i;
    s[0] = 1'b0;
    return s;
  endfunction

  always_comb begin
    target = is_indirect(kind) ? reg_rel(base_reg, imm) : pc_rel(pc, imm);
    link   = pc + STEP;
  end

endmodule

// File: rtl/ifid_reg.sv
module ifid_reg #(
  parameter int XLEN = 32,
  parameter int ILEN = 32,
  parameter logic [ILEN-1:0] NOP = 32'h0000_0013
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            squash,
  input  logic            hold,
  input  logic [ILEN-1:0] in_instr,
  input  logic [XLEN-1:0] in_pc,
  output logic [ILEN-1:0] out_instr,
  output logic [XLEN-1:0] out_pc
);

  always_ff @(posedge clk) begin
    if (!rst_n || squash) begin
      out_instr <= NOP;
      out_pc    <= '0;
    end else if (!hold) begin
      out_instr <= in_instr;
      out_pc    <= in_pc;
    end
  end

endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit #(
  parameter int XLEN = 32,
  parameter int ILEN = 32,
  parameter logic [ILEN-1:0] NOP = 32'h0000_0013
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dec_valid,
  input  logic            dec_stall,
  input  logic [3:0]      br_kind,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic [XLEN-1:0] dec_pc,
  input  logic [XLEN-1:0] dec_imm,
  input  logic [ILEN-1:0] fetch_instr,
  input  logic [XLEN-1:0] fetch_pc,
  output logic            redirect,
  output logic [XLEN-1:0] target,
  output logic [XLEN-1:0] link,
  output logic            flush,
  output logic [ILEN-1:0] ifid_instr,
  output logic [XLEN-1:0] ifid_pc
);

  // Named internal events for the checker.
  logic cond_true;
  logic eq_flag, lts_flag, ltu_flag;
  logic resolve_en;
  logic taken;

  br_compare #(.XLEN(XLEN)) u_cmp (
    .kind      (br_kind),
    .a         (src_a),
    .b         (src_b),
    .cond_true (cond_true),
    .eq_flag   (eq_flag),
    .lts_flag  (lts_flag),
    .ltu_flag  (ltu_flag)
  );

  br_target #(.XLEN(XLEN)) u_tgt (
    .kind     (br_kind),
    .pc       (dec_pc),
    .base_reg (src_a),
    .imm      (dec_imm),
    .target   (target),
    .link     (link)
  );

  // Resolution waits while decode is interlocked.
  assign resolve_en = dec_valid && !dec_stall;
  assign taken      = resolve_en && cond_true;
  assign redirect   = taken;
  assign flush      = taken;

  ifid_reg #(.XLEN(XLEN), .ILEN(ILEN), .NOP(NOP)) u_ifid (
    .clk       (clk),
    .rst_n     (rst_n),
    .squash    (flush),
    .hold      (dec_stall),
    .in_instr  (fetch_instr),
    .in_pc     (fetch_pc),
    .out_instr (ifid_instr),
    .out_pc    (ifid_pc)
  );

endmodule

// File: rtl/brres_checks.sv
module brres_checks #(
  parameter int XLEN = 32,
  parameter int ILEN = 32,
  parameter logic [ILEN-1:0] NOP = 32'h0000_0013
) (
  input logic            clk,
  input logic            rst_n,
  input logic            dec_valid,
  input logic            dec_stall,
  input logic [3:0]      br_kind,
  input logic [XLEN-1:0] src_a,
  input logic [XLEN-1:0] src_b,
  input logic [XLEN-1:0] dec_pc,
  input logic [XLEN-1:0] fetch_pc,
  input logic [ILEN-1:0] fetch_instr,
  input logic            redirect,
  input logic [XLEN-1:0] target,
  input logic [XLEN-1:0] link,
  input logic            flush,
  input logic            cond_true,
  input logic [ILEN-1:0] ifid_instr,
  input logic [XLEN-1:0] ifid_pc
);

  p_eq_cond_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_stall && br_kind == 4'd1) |-> (redirect == (src_a == src_b)));

  p_jal_link_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_stall && br_kind == 4'd7) |-> (redirect && link == dec_pc + XLEN'(4)));

  p_jalr_even_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && br_kind == 4'd8) |-> !target[0]);

  p_squash_nop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (ifid_instr == NOP && ifid_pc == '0));

  p_flush_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_stall && cond_true) |-> flush);

  p_fallthrough_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !dec_stall) |=> (ifid_instr == $past(fetch_instr) && ifid_pc == $past(fetch_pc)));

  p_stall_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_stall |-> (!redirect && !flush));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_stall |=> ($stable(ifid_instr) && $stable(ifid_pc)));

  p_none_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_valid || br_kind == 4'd0 || br_kind > 4'd8) |-> (!redirect && !flush));

endmodule

bind branch_resolve_unit brres_checks #(.XLEN(XLEN), .ILEN(ILEN), .NOP(NOP)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dec_valid   (dec_valid),
  .dec_stall   (dec_stall),
  .br_kind     (br_kind),
  .src_a       (src_a),
  .src_b       (src_b),
  .dec_pc      (dec_pc),
  .fetch_pc    (fetch_pc),
  .fetch_instr (fetch_instr),
  .redirect    (redirect),
  .target      (target),
  .link        (link),
  .flush       (flush),
  .cond_true   (cond_true),
  .ifid_instr  (ifid_instr),
  .ifid_pc     (ifid_pc)
);

// File: tb/sim_branch_resolve_unit.sv
module sim_branch_resolve_unit;
  localparam int XLEN = 32;
  localparam int ILEN = 32;
  localparam logic [31:0] NOPW = 32'h0000_0013;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            dec_valid, dec_stall;
  logic [3:0]      br_kind;
  logic [XLEN-1:0] src_a, src_b, dec_pc, dec_imm, fetch_pc;
  logic [ILEN-1:0] fetch_instr;
  logic            redirect, flush;
  logic [XLEN-1:0] target, link, ifid_pc;
  logic [ILEN-1:0] ifid_instr;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [ILEN-1:0] m_instr;
  logic [XLEN-1:0] m_pc;

  always #5 clk = ~clk;

  branch_resolve_unit #(.XLEN(XLEN), .ILEN(ILEN), .NOP(NOPW)) u0 (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_stall(dec_stall),
    .br_kind(br_kind), .src_a(src_a), .src_b(src_b), .dec_pc(dec_pc),
    .dec_imm(dec_imm), .fetch_instr(fetch_instr), .fetch_pc(fetch_pc),
    .redirect(redirect), .target(target), .link(link), .flush(flush),
    .ifid_instr(ifid_instr), .ifid_pc(ifid_pc)
  );

  function automatic bit want_taken(input logic [3:0] k, input logic [31:0] a,
                                    input logic [31:0] b);
    int signed sa, sb;
    sa = a; sb = b;
    case (k)
      4'd1: return a == b;
      4'd2: return a != b;
      4'd3: return sa < sb;
      4'd4: return sa >= sb;
      4'd5: return a < b;
      4'd6: return a >= b;
      4'd7, 4'd8: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] want_target(input logic [3:0] k, input logic [31:0] a,
                                              input logic [31:0] p, input logic [31:0] i);
    if (k == 4'd8) return (a + i) & 32'hFFFF_FFFE;
    return p + i;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit v, input bit st, input logic [3:0] k,
                      input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] p, input logic [31:0] i,
                      input logic [31:0] fi, input logic [31:0] fp);
    bit tk;
    string tg;
    @(negedge clk);
    dec_valid = v; dec_stall = st; br_kind = k; src_a = a; src_b = b;
    dec_pc = p; dec_imm = i; fetch_instr = fi; fetch_pc = fp;
    #1;
    tk = v && !st && want_taken(k, a, b);
    if (st) tg = "R8";
    else if (!v || k == 4'd0 || k > 4'd8) tg = "R9";
    else if (k == 4'd7) tg = "R4";
    else if (k == 4'd8) tg = "R5";
    else tg = "R2";
    chk(redirect == tk, {tg, " redirect"}, {31'd0, redirect}, {31'd0, tk});
    chk(flush == tk, tk ? "R6 flush" : (st ? "R8 flush" : "R7 flush"),
        {31'd0, flush}, {31'd0, tk});
    if (tk) begin
      chk(target == want_target(k, a, p, i),
          (k == 4'd8) ? "R5 target" : ((k == 4'd7) ? "R4 target" : "R3 target"),
          target, want_target(k, a, p, i));
      if (k >= 4'd7)
        chk(link == p + 32'd4, (k == 4'd7) ? "R4 link" : "R5 link", link, p + 32'd4);
    end
    if (tk) begin m_instr = NOPW; m_pc = '0; end
    else if (!st) begin m_instr = fi; m_pc = fp; end
    @(posedge clk);
    #1;
    tg = tk ? "R6 ifid" : (st ? "R8 ifid" : "R7 ifid");
    chk(ifid_instr == m_instr, {tg, " instr"}, ifid_instr, m_instr);
    chk(ifid_pc == m_pc, {tg, " pc"}, ifid_pc, m_pc);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5EED_0042);
    rst_n = 1'b0; dec_valid = 0; dec_stall = 0; br_kind = 0;
    src_a = 0; src_b = 0; dec_pc = 0; dec_imm = 0;
    fetch_instr = 32'hDEAD_BEEF; fetch_pc = 32'h40;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(ifid_instr == NOPW, "R1 reset instr", ifid_instr, NOPW);
    chk(ifid_pc == 32'd0, "R1 reset pc", ifid_pc, 32'd0);
    chk(!redirect && !flush, "R1 reset redirect", {31'd0, redirect}, 32'd0);
    rst_n = 1'b1;
    m_instr = NOPW; m_pc = '0;

    // Directed corners
    step(1, 0, 4'd1, 32'd7, 32'd7, 32'h100, 32'h20, 32'h1111_0001, 32'h104); // R2 eq taken
    step(1, 0, 4'd1, 32'd7, 32'd8, 32'h104, 32'h20, 32'h1111_0002, 32'h108); // R7 untaken
    step(1, 0, 4'd3, 32'hFFFF_FFFF, 32'd1, 32'h200, 32'hFFFF_FFF0, 32'h2, 32'h204); // R2 signed lt
    step(1, 0, 4'd5, 32'hFFFF_FFFF, 32'd1, 32'h200, 32'h8, 32'h3, 32'h204);         // R2 unsigned not lt
    step(1, 0, 4'd6, 32'hFFFF_FFFF, 32'd1, 32'h300, 32'h10, 32'h4, 32'h304);        // R3 target
    step(1, 0, 4'd4, 32'h8000_0000, 32'h7FFF_FFFF, 32'h300, 32'h10, 32'h5, 32'h304);
    step(1, 0, 4'd7, 32'd0, 32'd0, 32'h400, 32'hFFFF_FF00, 32'h6, 32'h404);        // R4
    step(1, 0, 4'd8, 32'h1001, 32'd0, 32'h500, 32'h4, 32'h7, 32'h504);             // R5 odd
    step(1, 1, 4'd7, 32'd0, 32'd0, 32'h600, 32'h40, 32'h8, 32'h604);               // R8 stall
    step(1, 1, 4'd1, 32'd3, 32'd3, 32'h600, 32'h40, 32'h9, 32'h604);               // R8 stall
    step(0, 0, 4'd7, 32'd0, 32'd0, 32'h700, 32'h40, 32'hA, 32'h704);               // R9 invalid
    step(1, 0, 4'd0, 32'd1, 32'd1, 32'h800, 32'h40, 32'hB, 32'h804);               // R9 none
    step(1, 0, 4'd12, 32'd1, 32'd1, 32'h900, 32'h40, 32'hC, 32'h904);              // R9 unused

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = ($urandom_range(0, 3) == 0) ? a : $urandom;
      if ($urandom_range(0, 3) == 0) b = {~a[31], a[30:0]};
      step($urandom_range(0, 7) != 0, $urandom_range(0, 5) == 0,
           4'($urandom_range(0, 11)), a, b, {$urandom, 2'b00} , $urandom,
           $urandom, {$urandom, 2'b00});
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule